// File: doc/BRIEF.md
# UART FIFO Interrupt Condition Generator

This block derives the transmit and receive interrupt requests of a UART whose buffers can work either as 16-entry FIFOs or as single holding registers. It takes the current occupancy of the transmit and receive buffers, a strobe for each received character, a strobe for each read by software, a bit-rate tick and the configured frame length in bits. From these it forms two raw interrupt conditions and two masked interrupt outputs.

With the FIFOs off, the transmit request means "holding register empty" and the receive request means "holding register has a character". With the FIFOs on, transmit requests service while at least half the FIFO is free. Receive requests service once the FIFO is at least half full, or once a partly filled FIFO has gone three character times without a new character or a read. A raised receive request in FIFO mode stays up until the FIFO is drained to empty. The idle timer counts bit-rate ticks against three times the frame length.

Top module: `uart_irq_gen`

## Requirements
- R1: With `fifo_en` low, `tx_raw` is 1 exactly when `tx_level` is 0 (holding register empty); a write that makes `tx_level` 1 clears it.
- R2: With `fifo_en` high, `tx_raw` is 1 exactly when the free space (16 minus `tx_level`) is 8 or more, i.e. `tx_level` is 8 or less.
- R3: With `fifo_en` low, `rx_raw` is 1 exactly when `rx_level` is nonzero, and 0 once the character is read (`rx_level` 0).
- R4: With `fifo_en` high, `rx_raw` is 1 in the same cycle that `rx_level` is 8 or more.
- R5: With `fifo_en` high, once `rx_raw` has been 1 it stays 1 while `rx_level` is nonzero, even below 8. It drops in the cycle `rx_level` reaches 0 and stays 0 after the FIFO refills below 8.
- R6: With `fifo_en` high and `rx_level` between 1 and 7, `rx_raw` rises right after the clock edge that samples the (3 x frame length)-th `bit_tick` counted since the last restart. It is still 0 after one tick fewer.
- R7: A cycle with `rx_push` or `rx_pop` high restarts the idle count, and so does a cycle with `rx_level` 0. A tick in that cycle is not counted.
- R8: `frame_bits` is clamped to the range 7 to 12. A value below 7 acts as 7 (timeout after 21 ticks), and a value above 12 acts as 12 (timeout after 36 ticks).
- R9: `tx_irq` equals `tx_raw` AND `tx_mask`, and `rx_irq` equals `rx_raw` AND `rx_mask`, in every cycle.
- R10: While `rst_n` is low, the idle count and the sticky receive flag are cleared. `rx_raw` then depends only on the present `rx_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: buffers act as FIFOs; 0: single holding registers |
| frame_bits | input | 4 | Frame length in bits (clamped to 7..12) |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| tx_level | input | 5 | Transmit buffer occupancy, 0..16 |
| rx_level | input | 5 | Receive buffer occupancy, 0..16 |
| rx_push | input | 1 | Strobe: a character was received |
| rx_pop | input | 1 | Strobe: software read a character |
| tx_mask | input | 1 | Transmit interrupt enable |
| rx_mask | input | 1 | Receive interrupt enable |
| tx_raw | output | 1 | Unmasked transmit condition |
| rx_raw | output | 1 | Unmasked receive condition |
| tx_irq | output | 1 | Masked transmit interrupt |
| rx_irq | output | 1 | Masked receive interrupt |

## Verification
The only internal state is the idle counter and the sticky receive flag. Both show up only on `rx_raw` and `rx_irq`. A counter that is off by one shows as a timeout one tick early or late. The bench therefore checks the output at both the (3F-1)-th and the 3F-th tick. A sticky flag that is not cleared shows as a stale receive request in the cycle after the FIFO empties and refills below half. A restart that is missed shows as a premature timeout within one character time of the suppressing push or read.

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
  parameter int DEPTH     = 16,
  parameter int OCC_W     = $clog2(DEPTH + 1),
  parameter int FLEN_W    = 4,
  parameter int FLEN_MIN  = 7,
  parameter int FLEN_MAX  = 12,
  parameter int TMO_CHARS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [FLEN_W-1:0] frame_bits,
  input  logic             bit_tick,
  input  logic [OCC_W-1:0] tx_level,
  input  logic [OCC_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             tx_mask,
  input  logic             rx_mask,
  output logic             tx_raw,
  output logic             rx_raw,
  output logic             tx_irq,
  output logic             rx_irq
);
  localparam int HALF  = DEPTH / 2;
  localparam int CNT_W = $clog2(TMO_CHARS * FLEN_MAX + 1);

  logic [FLEN_W-1:0] flen;
  logic [CNT_W-1:0]  limit, idle_cnt;
  logic [OCC_W-1:0]  tx_free;
  logic              rx_some, rx_half, restart, tmo_hit, held;

  assign flen = (frame_bits < FLEN_W'(FLEN_MIN)) ? FLEN_W'(FLEN_MIN) :
                (frame_bits > FLEN_W'(FLEN_MAX)) ? FLEN_W'(FLEN_MAX) : frame_bits;
  assign limit = CNT_W'(TMO_CHARS * int'(flen));

  assign tx_free = OCC_W'(DEPTH) - tx_level;
  assign rx_some = rx_level != '0;
  assign rx_half = rx_level >= OCC_W'(HALF);

  assign restart = !fifo_en || !rx_some || rx_push || rx_pop;
  assign tmo_hit = bit_tick && !restart && (idle_cnt + CNT_W'(1) >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      held     <= 1'b0;
    end else begin
      if (restart)
        idle_cnt <= '0;
      else if (bit_tick && idle_cnt < limit)
        idle_cnt <= idle_cnt + CNT_W'(1);

      if (!fifo_en || !rx_some)
        held <= 1'b0;
      else if (rx_half || tmo_hit)
        held <= 1'b1;
    end
  end

  assign tx_raw = fifo_en ? (tx_free >= OCC_W'(HALF)) : (tx_level == '0);
  assign rx_raw = fifo_en ? (rx_half || (held && rx_some)) : rx_some;
  assign tx_irq = tx_raw && tx_mask;
  assign rx_irq = rx_raw && rx_mask;
endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk #(
  parameter int DEPTH = 16,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             bit_tick,
  input logic [OCC_W-1:0] rx_level,
  input logic             rx_push,
  input logic             tx_mask,
  input logic             rx_mask,
  input logic             tx_raw,
  input logic             rx_raw,
  input logic             tx_irq,
  input logic             rx_irq
);
  // R9
  tx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq == (tx_raw && tx_mask));

  // R9
  rx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == (rx_raw && rx_mask));

  // R5
  rx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_raw) |=> (!fifo_en || rx_level == '0 || rx_raw));

  // R3
  rx_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !rx_raw);

  // R6
  no_tick_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !rx_raw && !bit_tick && !rx_push) |=>
      (!rx_raw || !fifo_en || rx_level >= OCC_W'(DEPTH / 2) || !$stable(rx_level)));
endmodule

bind uart_irq_gen uart_irq_gen_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .bit_tick(bit_tick),
  .rx_level(rx_level), .rx_push(rx_push), .tx_mask(tx_mask), .rx_mask(rx_mask),
  .tx_raw(tx_raw), .rx_raw(rx_raw), .tx_irq(tx_irq), .rx_irq(rx_irq)
);

// File: tb/sim_uart_irq_gen.sv
module sim_uart_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic [3:0] frame_bits = 4'd8;
  logic       bit_tick = 1'b0;
  logic [4:0] tx_level = '0;
  logic [4:0] rx_level = '0;
  logic       rx_push = 1'b0;
  logic       rx_pop = 1'b0;
  logic       tx_mask = 1'b0;
  logic       rx_mask = 1'b0;
  logic       tx_raw, rx_raw, tx_irq, rx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_gen u0 (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
    end
  endtask

  task automatic put_rx(logic [4:0] lvl, logic push, logic pop);
    @(negedge clk);
    rx_level = lvl; rx_push = push; rx_pop = pop;
    @(negedge clk);
    rx_push = 1'b0; rx_pop = 1'b0;
  endtask

  task automatic t_reset();
    rx_level = 5'd3; fifo_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 rx_raw in reset", rx_raw, 1'b0);
    chk("R10 tx_raw in reset", tx_raw, 1'b1);
    chk("R10 tx_irq masked in reset", tx_irq, 1'b0);
    rx_level = '0; fifo_en = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_tx_single();
    fifo_en = 1'b0; tx_level = '0; #1;
    chk("R1 empty holding reg", tx_raw, 1'b1);
    tx_level = 5'd1; #1;
    chk("R1 written holding reg", tx_raw, 1'b0);
  endtask

  task automatic t_tx_fifo();
    fifo_en = 1'b1;
    tx_level = 5'd8; #1;  chk("R2 8 free", tx_raw, 1'b1);
    tx_level = 5'd9; #1;  chk("R2 7 free", tx_raw, 1'b0);
    tx_level = 5'd16; #1; chk("R2 full", tx_raw, 1'b0);
    tx_level = 5'd0; #1;  chk("R2 empty", tx_raw, 1'b1);
  endtask

  task automatic t_rx_single();
    fifo_en = 1'b0;
    put_rx(5'd1, 1'b1, 1'b0);
    chk("R3 holding reg valid", rx_raw, 1'b1);
    ticks(40);
    chk("R3 still valid", rx_raw, 1'b1);
    put_rx(5'd0, 1'b0, 1'b1);
    chk("R3 read clears", rx_raw, 1'b0);
  endtask

  task automatic t_rx_half_sticky();
    fifo_en = 1'b1;
    put_rx(5'd7, 1'b1, 1'b0);
    chk("R4 seven stored", rx_raw, 1'b0);
    @(negedge clk) rx_level = 5'd8; rx_push = 1'b1; #1;
    chk("R4 eight stored same cycle", rx_raw, 1'b1);
    @(negedge clk) rx_push = 1'b0;
    put_rx(5'd3, 1'b0, 1'b1);
    chk("R5 stays below half", rx_raw, 1'b1);
    @(negedge clk) rx_level = 5'd0; #1;
    chk("R5 drops at empty", rx_raw, 1'b0);
    put_rx(5'd2, 1'b1, 1'b0);
    chk("R5 no stale after refill", rx_raw, 1'b0);
    put_rx(5'd0, 1'b0, 1'b1);
  endtask

  task automatic t_timeout(logic [3:0] fb, int lim, string tag);
    fifo_en = 1'b1; frame_bits = fb;
    put_rx(5'd2, 1'b1, 1'b0);
    ticks(lim - 1);
    chk({tag, " one tick short"}, rx_raw, 1'b0);
    ticks(1);
    chk({tag, " exact timeout"}, rx_raw, 1'b1);
    put_rx(5'd1, 1'b0, 1'b1);
    chk("R5 timeout sticky after read", rx_raw, 1'b1);
    put_rx(5'd0, 1'b0, 1'b1);
    chk("R5 timeout clears at empty", rx_raw, 1'b0);
    frame_bits = 4'd8;
  endtask

  task automatic t_restart();
    fifo_en = 1'b1; frame_bits = 4'd8;
    put_rx(5'd2, 1'b1, 1'b0);
    ticks(20);
    put_rx(5'd3, 1'b1, 1'b0);
    ticks(23);
    chk("R7 push restarts", rx_raw, 1'b0);
    ticks(1);
    chk("R7 timeout after push", rx_raw, 1'b1);
    put_rx(5'd0, 1'b0, 1'b1);
    put_rx(5'd4, 1'b1, 1'b0);
    ticks(22);
    put_rx(5'd3, 1'b0, 1'b1);
    ticks(23);
    chk("R7 pop restarts", rx_raw, 1'b0);
    @(negedge clk) rx_pop = 1'b1; bit_tick = 1'b1; rx_level = 5'd2;
    @(negedge clk) rx_pop = 1'b0; bit_tick = 1'b0;
    ticks(23);
    chk("R7 tick in pop cycle not counted", rx_raw, 1'b0);
    ticks(1);
    chk("R7 timeout after pop", rx_raw, 1'b1);
    put_rx(5'd0, 1'b0, 1'b1);
  endtask

  task automatic t_mask();
    fifo_en = 1'b1; tx_level = '0;
    put_rx(5'd9, 1'b1, 1'b0);
    tx_mask = 1'b0; rx_mask = 1'b0; #1;
    chk("R9 tx masked", tx_irq, 1'b0);
    chk("R9 rx masked", rx_irq, 1'b0);
    chk("R9 raw visible", rx_raw, 1'b1);
    tx_mask = 1'b1; rx_mask = 1'b1; #1;
    chk("R9 tx enabled", tx_irq, 1'b1);
    chk("R9 rx enabled", rx_irq, 1'b1);
    tx_level = 5'd12; #1;
    chk("R9 tx follows raw", tx_irq, 1'b0);
    put_rx(5'd0, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_tx_single();
    t_tx_fifo();
    t_rx_single();
    t_rx_half_sticky();
    t_timeout(4'd8, 24, "R6 frame 8");
    t_timeout(4'd3, 21, "R8 clamp low");
    t_timeout(4'd15, 36, "R8 clamp high");
    t_restart();
    t_mask();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule